// File: doc/BRIEF.md
# Write-Through Burst Builder

This block sits between a write-through data cache and the interconnect. Every processor store enters it as one word (address, data, per-byte enables) on a valid/ready stream. Stores that fall in the same 32-byte aligned block, and that arrive without a gap, are merged into a single block image. Each block image leaves as one burst. A burst starts with a header beat that carries the base address and the word count. Data beats follow, one per word, and the final data beat is marked last.

Two block slots are kept. One slot fills while the other drains. A store to a new block closes the block that is filling. A store cycle with nothing accepted also closes the filling block, but only while no burst is waiting or going out. A read-side query reports whether any address inside a pending block matches, so that the cache can hold a read until the write reaches memory.

Top module: `wr_burst_buf`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `rd_match` is 0.
- R2: Stores to the open block merge into its word slot. The slot's byte enable becomes the OR of the stores' enables. A byte lane written twice keeps the data of the later store, and lanes never written go out as zero data.
- R3: An accepted store to a block other than the open one closes the open block. Bursts leave in the order their blocks were opened.
- R4: A burst covers the lowest to the highest word written in its block. The header beat (`out_hdr`=1) gives the address of the lowest word and `out_len` = highest - lowest + 1, in the range 1..8. Data beats follow in rising word order. Each data beat carries its own word address (address bits [4:2] are the word index). Only the final data beat has `out_last`=1, and unwritten words in between carry byte enable 0.
- R5: A store with byte enable 0000 is accepted and marks its word as written. It widens the burst range but changes no data.
- R6: In a cycle where no store is accepted and no closed block is pending, the open block is closed.
- R7: When both slots are occupied, `in_ready` is 0 for a store to any block other than the open one. A store to the open block is still accepted.
- R8: `rd_match` is 1 exactly when `rd_addr[39:5]` equals the block of a slot that is open or not yet fully sent. It drops after the last beat of that block is accepted.
- R9: While `out_valid`=1 and `out_ready`=0, every output beat field stays unchanged in the next cycle.
- R10: No burst crosses its 32-byte block: in a header beat, word index + `out_len` is at most 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Store request valid |
| in_ready | output | 1 | Store accepted at this edge when valid |
| in_addr | input | 40 | Store byte address (word aligned) |
| in_data | input | 32 | Store data |
| in_be | input | 4 | Store byte enables, may be zero |
| out_valid | output | 1 | Burst beat valid |
| out_ready | input | 1 | Interconnect takes the beat |
| out_hdr | output | 1 | Beat is the header beat |
| out_addr | output | 40 | Base address (header) or word address (data) |
| out_len | output | 4 | Burst length in words, 1..8 |
| out_data | output | 32 | Word data on data beats |
| out_be | output | 4 | Word byte enables on data beats |
| out_last | output | 1 | Final data beat of the burst |
| rd_addr | input | 40 | Read address to compare with pending blocks |
| rd_match | output | 1 | Read address falls in a pending block |

## Verification
The hardest state to reach is the one where both slots are full: one closed block is waiting on the interconnect and the other is still filling. In that state a new-block store must stall while a same-block store still merges. The bench gets there by holding `out_ready` low, letting a first block close by itself, and then opening a second block. It then offers a foreign store and a same-block store in the same half-cycle. In the main sequence, a third block arrives while the first is still draining, which forces a stall in the middle of a back-to-back stream of stores.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    localparam int ADDR_W = 40;
    localparam int DATA_W = 32;
    localparam int WORDS  = 8;
    localparam int SLOTS  = 2;
    localparam int BE_W   = DATA_W / 8;
    localparam int WIDX_W = $clog2(WORDS);
    localparam int OFS_W  = WIDX_W + $clog2(BE_W);
    localparam int BLK_W  = ADDR_W - OFS_W;
    localparam int LEN_W  = WIDX_W + 1;
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    typedef enum logic [1:0] {SL_EMPTY, SL_OPEN, SL_CLOSED} slot_st_e;
    typedef enum logic [1:0] {DR_IDLE, DR_HEAD, DR_DATA} drain_st_e;

    typedef struct packed {
        slot_st_e                         st;
        logic [BLK_W-1:0]                 blk;
        logic [WORDS-1:0]                 mask;
        logic [WORDS-1:0][BE_W-1:0]       be;
        logic [WORDS-1:0][DATA_W-1:0]     data;
    } slot_t;

    function automatic logic [WIDX_W-1:0] low_word(input logic [WORDS-1:0] m);
        logic [WIDX_W-1:0] r;
        r = '0;
        for (int i = WORDS - 1; i >= 0; i--)
            if (m[i]) r = WIDX_W'(i);
        return r;
    endfunction

    function automatic logic [WIDX_W-1:0] high_word(input logic [WORDS-1:0] m);
        logic [WIDX_W-1:0] r;
        r = '0;
        for (int i = 0; i < WORDS; i++)
            if (m[i]) r = WIDX_W'(i);
        return r;
    endfunction
endpackage

// File: rtl/wbuf_slot.sv
module wbuf_slot
    import wbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc,
    input  logic              merge,
    input  logic              close,
    input  logic              free_i,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic [BE_W-1:0]   st_be,
    output slot_t             slot
);
    logic [WIDX_W-1:0] widx;
    slot_t             nxt;

    assign widx = st_addr[OFS_W-1 -: WIDX_W];

    always_comb begin
        nxt = slot;
        if (alloc) begin
            nxt.st   = SL_OPEN;
            nxt.blk  = st_addr[ADDR_W-1:OFS_W];
            nxt.mask = '0;
            nxt.be   = '0;
            nxt.data = '0;
        end
        if (alloc || merge) begin
            nxt.mask[widx] = 1'b1;
            nxt.be[widx]   = nxt.be[widx] | st_be;
            for (int b = 0; b < BE_W; b++)
                if (st_be[b]) nxt.data[widx][b*8 +: 8] = st_data[b*8 +: 8];
        end
        if (close)  nxt.st = SL_CLOSED;
        if (free_i) nxt.st = SL_EMPTY;
    end

    always_ff @(posedge clk) begin
        if (rst) slot <= '0;
        else     slot <= nxt;
    end
endmodule

// File: rtl/wbuf_drain.sv
module wbuf_drain
    import wbuf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  slot_t [SLOTS-1:0]     slots,
    input  logic                  out_ready,
    output logic                  out_valid,
    output logic                  out_hdr,
    output logic [ADDR_W-1:0]     out_addr,
    output logic [LEN_W-1:0]      out_len,
    output logic [DATA_W-1:0]     out_data,
    output logic [BE_W-1:0]       out_be,
    output logic                  out_last,
    output logic [SLOTS-1:0]      free_o
);
    drain_st_e          st;
    logic [SLOT_W-1:0]  sel;
    logic [SLOT_W-1:0]  pick;
    logic               found;
    logic [WIDX_W-1:0]  widx;
    logic [WIDX_W-1:0]  lo;
    logic [WIDX_W-1:0]  hi;
    slot_t              cur;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int s = 0; s < SLOTS; s++)
            if (!found && slots[s].st == SL_CLOSED) begin
                found = 1'b1;
                pick  = SLOT_W'(s);
            end
    end

    assign cur = slots[sel];
    assign lo  = low_word(cur.mask);
    assign hi  = high_word(cur.mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= DR_IDLE;
            sel  <= '0;
            widx <= '0;
        end else begin
            case (st)
                DR_IDLE: if (found) begin
                    sel <= pick;
                    st  <= DR_HEAD;
                end
                DR_HEAD: if (out_ready) begin
                    widx <= lo;
                    st   <= DR_DATA;
                end
                DR_DATA: if (out_ready) begin
                    if (widx == hi) st <= DR_IDLE;
                    else            widx <= widx + WIDX_W'(1);
                end
                default: st <= DR_IDLE;
            endcase
        end
    end

    always_comb begin
        out_valid = (st != DR_IDLE);
        out_hdr   = (st == DR_HEAD);
        out_len   = LEN_W'(hi) - LEN_W'(lo) + LEN_W'(1);
        out_addr  = {cur.blk, (st == DR_DATA) ? widx : lo, {(OFS_W-WIDX_W){1'b0}}};
        out_data  = (st == DR_DATA) ? cur.data[widx] : '0;
        out_be    = (st == DR_DATA) ? cur.be[widx]   : '0;
        out_last  = (st == DR_DATA) && (widx == hi);
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_free
        assign free_o[g] = out_last && out_ready && (sel == SLOT_W'(g));
    end
endmodule

// File: rtl/wr_burst_buf.sv
module wr_burst_buf
    import wbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic [BE_W-1:0]   in_be,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_hdr,
    output logic [ADDR_W-1:0] out_addr,
    output logic [LEN_W-1:0]  out_len,
    output logic [DATA_W-1:0] out_data,
    output logic [BE_W-1:0]   out_be,
    output logic              out_last,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_match
);
    slot_t [SLOTS-1:0] slots;
    logic  [SLOTS-1:0] is_open, is_closed, is_empty, blk_hit, rd_hit;
    logic  [SLOTS-1:0] alloc_v, merge_v, close_v, free_v;
    logic  [SLOT_W-1:0] first_empty;
    logic               hit, accept;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        wbuf_slot u_slot (
            .clk     (clk),
            .rst     (rst),
            .alloc   (alloc_v[g]),
            .merge   (merge_v[g]),
            .close   (close_v[g]),
            .free_i  (free_v[g]),
            .st_addr (in_addr),
            .st_data (in_data),
            .st_be   (in_be),
            .slot    (slots[g])
        );
        assign is_open[g]   = (slots[g].st == SL_OPEN);
        assign is_closed[g] = (slots[g].st == SL_CLOSED);
        assign is_empty[g]  = (slots[g].st == SL_EMPTY);
        assign blk_hit[g]   = is_open[g] && (slots[g].blk == in_addr[ADDR_W-1:OFS_W]);
        assign rd_hit[g]    = !is_empty[g] && (slots[g].blk == rd_addr[ADDR_W-1:OFS_W]);
        assign merge_v[g]   = accept && blk_hit[g];
        assign alloc_v[g]   = accept && !hit && (first_empty == SLOT_W'(g));
        assign close_v[g]   = is_open[g] &&
                              ((accept && !hit) || (!accept && !(|is_closed)));
    end

    always_comb begin
        first_empty = '0;
        for (int s = SLOTS - 1; s >= 0; s--)
            if (is_empty[s]) first_empty = SLOT_W'(s);
    end

    assign hit      = |blk_hit;
    assign in_ready = hit || (|is_empty);
    assign accept   = in_valid && in_ready;
    assign rd_match = |rd_hit;

    wbuf_drain u_drain (
        .clk       (clk),
        .rst       (rst),
        .slots     (slots),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_hdr   (out_hdr),
        .out_addr  (out_addr),
        .out_len   (out_len),
        .out_data  (out_data),
        .out_be    (out_be),
        .out_last  (out_last),
        .free_o    (free_v)
    );
endmodule

// File: rtl/wr_burst_buf_chk.sv
module wr_burst_buf_chk
    import wbuf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [ADDR_W-1:0] in_addr,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_hdr,
    input logic [ADDR_W-1:0] out_addr,
    input logic [LEN_W-1:0]  out_len,
    input logic [DATA_W-1:0] out_data,
    input logic [BE_W-1:0]   out_be,
    input logic              out_last,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_match
);
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_hdr) && $stable(out_addr)
            && $stable(out_len) && $stable(out_data) && $stable(out_be) && $stable(out_last));

    assert_in_block_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_hdr |-> (out_len != '0) &&
            (int'(out_addr[OFS_W-1 -: WIDX_W]) + int'(out_len) <= WORDS));

    assert_last_ends_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && out_last |=> !out_valid);

    assert_data_follows_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && out_hdr |=> out_valid && !out_hdr);

    assert_pending_match_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && (rd_addr[ADDR_W-1:OFS_W] == in_addr[ADDR_W-1:OFS_W])
            |=> (!$stable(rd_addr) || rd_match));
endmodule

bind wr_burst_buf wr_burst_buf_chk u_chk (.*);

// File: tb/wr_burst_buf_bench.sv
`timescale 1ns/1ps
module wr_burst_buf_bench;
    localparam time CLK_T = 8ns;

    typedef struct packed {
        logic [39:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
    } st_t;

    typedef struct packed {
        logic        hdr;
        logic [39:0] addr;
        logic [3:0]  len;
        logic [31:0] data;
        logic [3:0]  be;
        logic        last;
    } beat_t;

    localparam int NST = 8;
    localparam int NBT = 17;

    localparam st_t STIM [NST] = '{
        '{40'h00_1000_0008, 32'h1111_1111, 4'hF},
        '{40'h00_1000_0008, 32'hAABB_CCDD, 4'h3},
        '{40'h00_1000_0014, 32'h5555_5555, 4'h0},
        '{40'h00_1000_0004, 32'h2222_2222, 4'h8},
        '{40'h00_1000_003C, 32'h7777_7777, 4'hF},
        '{40'h00_1000_003C, 32'h9999_9999, 4'h0},
        '{40'h80_0000_0040, 32'h0102_0304, 4'h6},
        '{40'h80_0000_005C, 32'hDEAD_BEEF, 4'hF}
    };

    localparam beat_t EXP [NBT] = '{
        '{1'b1, 40'h00_1000_0004, 4'd5, 32'h0,          4'h0, 1'b0},
        '{1'b0, 40'h00_1000_0004, 4'd5, 32'h2200_0000,  4'h8, 1'b0},
        '{1'b0, 40'h00_1000_0008, 4'd5, 32'h1111_CCDD,  4'hF, 1'b0},
        '{1'b0, 40'h00_1000_000C, 4'd5, 32'h0,          4'h0, 1'b0},
        '{1'b0, 40'h00_1000_0010, 4'd5, 32'h0,          4'h0, 1'b0},
        '{1'b0, 40'h00_1000_0014, 4'd5, 32'h0,          4'h0, 1'b1},
        '{1'b1, 40'h00_1000_003C, 4'd1, 32'h0,          4'h0, 1'b0},
        '{1'b0, 40'h00_1000_003C, 4'd1, 32'h7777_7777,  4'hF, 1'b1},
        '{1'b1, 40'h80_0000_0040, 4'd8, 32'h0,          4'h0, 1'b0},
        '{1'b0, 40'h80_0000_0040, 4'd8, 32'h0002_0300,  4'h6, 1'b0},
        '{1'b0, 40'h80_0000_0044, 4'd8, 32'h0,          4'h0, 1'b0},
        '{1'b0, 40'h80_0000_0048, 4'd8, 32'h0,          4'h0, 1'b0},
        '{1'b0, 40'h80_0000_004C, 4'd8, 32'h0,          4'h0, 1'b0},
        '{1'b0, 40'h80_0000_0050, 4'd8, 32'h0,          4'h0, 1'b0},
        '{1'b0, 40'h80_0000_0054, 4'd8, 32'h0,          4'h0, 1'b0},
        '{1'b0, 40'h80_0000_0058, 4'd8, 32'h0,          4'h0, 1'b0},
        '{1'b0, 40'h80_0000_005C, 4'd8, 32'hDEAD_BEEF,  4'hF, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [39:0] in_addr = '0;
    logic [31:0] in_data = '0;
    logic [3:0]  in_be = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic        out_hdr;
    logic [39:0] out_addr;
    logic [3:0]  out_len;
    logic [31:0] out_data;
    logic [3:0]  out_be;
    logic        out_last;
    logic [39:0] rd_addr = '0;
    logic        rd_match;

    int    nchecks = 0;
    int    nerr = 0;
    int    ncap = 0;
    beat_t cap [32];
    bit    done = 1'b0;

    always #(CLK_T/2) clk = ~clk;

    wr_burst_buf u_wr_burst_buf (.*);

    always @(negedge clk) begin
        if (!rst && out_valid && out_ready && ncap < 32) begin
            cap[ncap] = '{out_hdr, out_addr, out_len, out_data, out_be, out_last};
            ncap = ncap + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after the store is taken
    task automatic send(input logic [39:0] a, input logic [31:0] d, input logic [3:0] b);
        in_valid = 1'b1;
        in_addr  = a;
        in_data  = d;
        in_be    = b;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
    endtask

    task automatic set_ready(input logic r);
        @(posedge clk);
        #1 out_ready = r;
        @(negedge clk);
    endtask

    function automatic string beat_req(input int i);
        case (i)
            2:       return "R2";
            5:       return "R5";
            6, 7:    return "R3";
            default: return (i >= 8) ? "R6" : "R4";
        endcase
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(in_ready == 1'b1, "R1 in_ready", 96'(in_ready), 96'(1));
        chk(out_valid == 1'b0, "R1 out_valid", 96'(out_valid), 96'(0));
        chk(rd_match == 1'b0, "R1 rd_match", 96'(rd_match), 96'(0));

        // table-driven stream: merging, gaps, zero-enable word, stall on third block
        set_ready(1'b1);
        @(posedge clk);
        ncap = 0;
        @(negedge clk);
        for (int i = 0; i < NST; i++)
            send(STIM[i].addr, STIM[i].data, STIM[i].be);
        in_valid = 1'b0;
        for (int k = 0; k < 400 && ncap < NBT; k++) @(negedge clk);
        chk(ncap == NBT, "R3 beat count", 96'(ncap), 96'(NBT));
        for (int i = 0; i < NBT; i++)
            chk(cap[i] == EXP[i], beat_req(i), 96'(cap[i]), 96'(EXP[i]));

        // directed: query match, back-pressure, full-buffer stall and merge
        set_ready(1'b0);
        @(posedge clk);
        ncap = 0;
        @(negedge clk);
        send(40'h00_2000_000C, 32'h0A0A_0A0A, 4'hF);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rd_addr = 40'h00_2000_001F;
        #1 chk(rd_match == 1'b1, "R8 inside pending block", 96'(rd_match), 96'(1));
        rd_addr = 40'h00_2000_0020;
        #1 chk(rd_match == 1'b0, "R8 next block", 96'(rd_match), 96'(0));
        chk(out_valid && out_hdr, "R6 idle close gives header", 96'({out_valid, out_hdr}), 96'(3));
        begin
            logic [39:0] held;
            held = out_addr;
            @(negedge clk);
            chk(out_valid && out_hdr && out_addr == held, "R9 held beat", 96'(out_addr), 96'(held));
        end
        send(40'h00_3000_0000, 32'h0B0B_0B0B, 4'hF);
        in_addr = 40'h00_4000_0000;
        #1 chk(in_ready == 1'b0, "R7 foreign store stalls", 96'(in_ready), 96'(0));
        send(40'h00_3000_0004, 32'h0C0C_0C0C, 4'h1);
        in_valid = 1'b0;
        rd_addr = 40'h00_3000_0010;
        #1 chk(rd_match == 1'b1, "R8 open block", 96'(rd_match), 96'(1));
        set_ready(1'b1);
        for (int k = 0; k < 100 && ncap < 5; k++) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(ncap == 5, "R7 beats after stall", 96'(ncap), 96'(5));
        chk(cap[0].hdr && cap[0].addr == 40'h00_2000_000C && cap[0].len == 4'd1,
            "R4 first header", 96'(cap[0]), 96'({1'b1, 40'h00_2000_000C, 4'd1, 37'd0}));
        chk(cap[2].hdr && cap[2].addr == 40'h00_3000_0000 && cap[2].len == 4'd2,
            "R7 merged second header", 96'(cap[2]), 96'({1'b1, 40'h00_3000_0000, 4'd2, 37'd0}));
        chk(cap[4] == beat_t'({1'b0, 40'h00_3000_0004, 4'd2, 32'h0000_000C, 4'h1, 1'b1}),
            "R2 merged word", 96'(cap[4]),
            96'(beat_t'({1'b0, 40'h00_3000_0004, 4'd2, 32'h0000_000C, 4'h1, 1'b1})));
        #1 chk(rd_match == 1'b0, "R8 drops after drain", 96'(rd_match), 96'(0));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchecks);
        $finish;
    end

    initial begin
        #(CLK_T * 100000);
        if (!done) begin
            nchecks++;
            nerr++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchecks);
            $finish;
        end
    end
endmodule